// File: doc/BRIEF.md
# Trap Return State Restore Unit

This block carries out the two ways of returning from a trap handler. It holds a small per-level trap stack: a saved PC, a saved next-PC, a packed saved-state word and a trap type for each level. It also holds the current trap level. A return request uses a one-bit function code to pick its flavour. The block checks privilege and the trap level. It reads the stack entry at the current level and unpacks three fields from the saved-state word: window pointer, processor state and address-space identifier. It rebuilds the PC pair that execution resumes from and lowers the trap level by one.

The two flavours differ only in how the PC pair is rebuilt. The "done" flavour skips the trapped instruction and resumes at the saved next-PC. The "retry" flavour re-executes the trapped instruction, starting from the saved PC. Software can write any of the four stack entries at the current level. It can also set the trap level directly. A combinational read port shows the entries at the current level. All results, including faults, appear one cycle after the request as single-cycle strobes.

Top module: `trap_ret_unit`

## Requirements
- R1: After reset the trap level is 0, the read port returns 0, and `ret_vld_o`, `illegal_o` and `priv_fault_o` are low.
- R2: A return request while `priv_i` and `hpriv_i` are both 0 raises `priv_fault_o` in the next cycle and changes no state. This fault takes priority over the trap-level check, so it is also raised at trap level 0.
- R3: A privileged return request at trap level 0 raises `illegal_o` in the next cycle and leaves the trap level and the stack unchanged.
- R4: A successful return presents the restored fields in the next cycle, taken from the saved-state word of the level that was current at the request: `cwp_o` is bits 4:0, `pstate_o` is bits 20:8 and `asi_o` is bits 31:24.
- R5: With `ret_fcn_i`=0 (done), `npc_o` is the saved next-PC and `nnpc_o` is the saved next-PC plus 4, wrapping modulo 2^PC_W.
- R6: With `ret_fcn_i`=1 (retry), `npc_o` is the saved PC and `nnpc_o` is the saved next-PC.
- R7: A successful return lowers the trap level by exactly one, visible on `tl_o` in the next cycle. The entry is read before the level drops.
- R8: A stack write at trap level 0 raises `illegal_o` in the next cycle and changes no stack entry.
- R9: A stack write at a nonzero level updates only the entry that `wr_sel_i` selects at the current level. The encoding is 0 = saved PC, 1 = saved next-PC, 2 = saved-state word (low 32 bits kept), 3 = trap type (low 9 bits kept). `rd_sel_i` uses the same encoding and the read port shows the value zero-extended.
- R10: `tl_set_i` loads the trap level from `tl_val_i` and saturates at MAX_TL (6).
- R11: Request priority is return, then trap-level set, then stack write; lower-priority requests in the same cycle are ignored. Each request gives at most one of `ret_vld_o`, `illegal_o` or `priv_fault_o`, and the strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 1 | Privileged mode bit |
| hpriv_i | input | 1 | Hyperprivileged mode bit |
| ret_req_i | input | 1 | Trap return request |
| ret_fcn_i | input | 1 | 0 = done, 1 = retry |
| tl_set_i | input | 1 | Load trap level |
| tl_val_i | input | 3 | Trap level to load |
| wr_req_i | input | 1 | Stack entry write at current level |
| wr_sel_i | input | 2 | Entry select for write |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Entry select for read port |
| rd_data_o | output | 64 | Entry at current level, zero-extended |
| tl_o | output | 3 | Current trap level |
| ret_vld_o | output | 1 | Successful return strobe |
| cwp_o | output | 5 | Restored window pointer |
| pstate_o | output | 13 | Restored processor state |
| asi_o | output | 8 | Restored address-space identifier |
| npc_o | output | 64 | New next PC |
| nnpc_o | output | 64 | New following PC |
| illegal_o | output | 1 | Illegal-instruction strobe |
| priv_fault_o | output | 1 | Privileged-action strobe |

## Verification
The assertions check several rules on every cycle: the trap-level bound, the decrement by one after a return, the priority of the privilege fault, the fault at level 0, and that the outcome strobes never overlap. They also check that the done PC pair differs by four, that retry takes its PC from the stack, and that the stack never accepts a write at level 0. Other behaviour can only be shown by the bench scenarios. These are the exact bit positions of the unpacked fields, and that a write rejected at level 0 leaves level 1 untouched. They also cover the truncation of the state and type entries, the wrap of the done PC at all-ones, and that a write issued alongside a return is dropped.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    SEL_TPC    = 2'd0,
    SEL_TNPC   = 2'd1,
    SEL_TSTATE = 2'd2,
    SEL_TT     = 2'd3
  } trs_sel_e;

  localparam int CWP_LO = 0;
  localparam int CWP_HI = 4;
  localparam int PST_LO = 8;
  localparam int PST_HI = 20;
  localparam int ASI_LO = 24;
  localparam int ASI_HI = 31;
  localparam int CWP_W  = CWP_HI - CWP_LO + 1;
  localparam int PST_W  = PST_HI - PST_LO + 1;
  localparam int ASI_W  = ASI_HI - ASI_LO + 1;
endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl #(
  parameter int MAX_TL = 6,
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            priv_i,
  input  logic            hpriv_i,
  input  logic            ret_req_i,
  input  logic            tl_set_i,
  input  logic [TL_W-1:0] tl_val_i,
  input  logic            wr_req_i,
  output logic [TL_W-1:0] tl_o,
  output logic            ret_ok_o,
  output logic            ret_tl_bad_o,
  output logic            ret_priv_bad_o,
  output logic            wr_ok_o,
  output logic            wr_bad_o
);
  logic [TL_W-1:0] tl_q;
  logic            tl_zero;
  logic            priv_ok;
  logic            set_act;
  logic            wr_act;

  assign tl_zero        = (tl_q == '0);
  assign priv_ok        = priv_i | hpriv_i;
  assign ret_priv_bad_o = ret_req_i & ~priv_ok;
  assign ret_tl_bad_o   = ret_req_i & priv_ok & tl_zero;
  assign ret_ok_o       = ret_req_i & priv_ok & ~tl_zero;
  assign set_act        = ~ret_req_i & tl_set_i;
  assign wr_act         = ~ret_req_i & ~tl_set_i & wr_req_i;
  assign wr_ok_o        = wr_act & ~tl_zero;
  assign wr_bad_o       = wr_act & tl_zero;
  assign tl_o           = tl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0;
    end else if (ret_ok_o) begin
      tl_q <= tl_q - TL_W'(1);
    end else if (set_act) begin
      tl_q <= (tl_val_i > TL_W'(MAX_TL)) ? TL_W'(MAX_TL) : tl_val_i;
    end
  end

  assert_tl_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_q <= TL_W'(MAX_TL));

  assert_tl_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ok_o |=> tl_q == $past(tl_q) - TL_W'(1));
endmodule

// File: rtl/trs_stack.sv
module trs_stack
  import trs_pkg::*;
#(
  parameter int MAX_TL   = 6,
  parameter int PC_W     = 64,
  parameter int TSTATE_W = 32,
  parameter int TT_W     = 9,
  parameter int DATA_W   = 64,
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TL_W-1:0]     level_i,
  input  logic                wr_en_i,
  input  trs_sel_e            wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [PC_W-1:0]     tpc_o,
  output logic [PC_W-1:0]     tnpc_o,
  output logic [TSTATE_W-1:0] tstate_o,
  output logic [TT_W-1:0]     tt_o
);
  logic [PC_W-1:0]     tpc_q    [MAX_TL];
  logic [PC_W-1:0]     tnpc_q   [MAX_TL];
  logic [TSTATE_W-1:0] tstate_q [MAX_TL];
  logic [TT_W-1:0]     tt_q     [MAX_TL];

  for (genvar g = 0; g < MAX_TL; g++) begin : g_lvl
    logic hit;
    assign hit = wr_en_i && (level_i == TL_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tpc_q[g]    <= '0;
        tnpc_q[g]   <= '0;
        tstate_q[g] <= '0;
        tt_q[g]     <= '0;
      end else if (hit) begin
        unique case (wr_sel_i)
          SEL_TPC:    tpc_q[g]    <= wr_data_i[PC_W-1:0];
          SEL_TNPC:   tnpc_q[g]   <= wr_data_i[PC_W-1:0];
          SEL_TSTATE: tstate_q[g] <= wr_data_i[TSTATE_W-1:0];
          default:    tt_q[g]     <= wr_data_i[TT_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    tpc_o    = '0;
    tnpc_o   = '0;
    tstate_o = '0;
    tt_o     = '0;
    for (int i = 0; i < MAX_TL; i++) begin
      if (level_i == TL_W'(i + 1)) begin
        tpc_o    = tpc_q[i];
        tnpc_o   = tnpc_q[i];
        tstate_o = tstate_q[i];
        tt_o     = tt_q[i];
      end
    end
  end

  assert_no_wr_at_tl0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> level_i != '0);
endmodule

// File: rtl/trs_rebuild.sv
module trs_rebuild
  import trs_pkg::*;
#(
  parameter int PC_W     = 64,
  parameter int TSTATE_W = 32
) (
  input  logic                fcn_i,
  input  logic [PC_W-1:0]     tpc_i,
  input  logic [PC_W-1:0]     tnpc_i,
  input  logic [TSTATE_W-1:0] tstate_i,
  output logic [CWP_W-1:0]    cwp_o,
  output logic [PST_W-1:0]    pstate_o,
  output logic [ASI_W-1:0]    asi_o,
  output logic [PC_W-1:0]     npc_o,
  output logic [PC_W-1:0]     nnpc_o
);
  assign cwp_o    = tstate_i[CWP_HI:CWP_LO];
  assign pstate_o = tstate_i[PST_HI:PST_LO];
  assign asi_o    = tstate_i[ASI_HI:ASI_LO];

  // fcn 0: resume after trapped instr; fcn 1: re-execute it
  always_comb begin
    if (fcn_i) begin
      npc_o  = tpc_i;
      nnpc_o = tnpc_i;
    end else begin
      npc_o  = tnpc_i;
      nnpc_o = tnpc_i + PC_W'(4);
    end
  end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
  import trs_pkg::*;
#(
  parameter int MAX_TL   = 6,
  parameter int PC_W     = 64,
  parameter int TSTATE_W = 32,
  parameter int TT_W     = 9,
  parameter int DATA_W   = 64,
  localparam int TL_W = $clog2(MAX_TL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              hpriv_i,
  input  logic              ret_req_i,
  input  logic              ret_fcn_i,
  input  logic              tl_set_i,
  input  logic [TL_W-1:0]   tl_val_i,
  input  logic              wr_req_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TL_W-1:0]   tl_o,
  output logic              ret_vld_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [ASI_W-1:0]  asi_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [PC_W-1:0]   nnpc_o,
  output logic              illegal_o,
  output logic              priv_fault_o
);
  logic                ret_ok, ret_tl_bad, ret_priv_bad, wr_ok, wr_bad;
  logic [PC_W-1:0]     tpc_rd, tnpc_rd, npc_d, nnpc_d;
  logic [TSTATE_W-1:0] tstate_rd;
  logic [TT_W-1:0]     tt_rd;
  logic [CWP_W-1:0]    cwp_d;
  logic [PST_W-1:0]    pst_d;
  logic [ASI_W-1:0]    asi_d;

  trs_ctrl #(.MAX_TL(MAX_TL)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .priv_i        (priv_i),
    .hpriv_i       (hpriv_i),
    .ret_req_i     (ret_req_i),
    .tl_set_i      (tl_set_i),
    .tl_val_i      (tl_val_i),
    .wr_req_i      (wr_req_i),
    .tl_o          (tl_o),
    .ret_ok_o      (ret_ok),
    .ret_tl_bad_o  (ret_tl_bad),
    .ret_priv_bad_o(ret_priv_bad),
    .wr_ok_o       (wr_ok),
    .wr_bad_o      (wr_bad)
  );

  trs_stack #(
    .MAX_TL(MAX_TL), .PC_W(PC_W), .TSTATE_W(TSTATE_W), .TT_W(TT_W), .DATA_W(DATA_W)
  ) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (tl_o),
    .wr_en_i  (wr_ok),
    .wr_sel_i (trs_sel_e'(wr_sel_i)),
    .wr_data_i(wr_data_i),
    .tpc_o    (tpc_rd),
    .tnpc_o   (tnpc_rd),
    .tstate_o (tstate_rd),
    .tt_o     (tt_rd)
  );

  trs_rebuild #(.PC_W(PC_W), .TSTATE_W(TSTATE_W)) u_rebuild (
    .fcn_i   (ret_fcn_i),
    .tpc_i   (tpc_rd),
    .tnpc_i  (tnpc_rd),
    .tstate_i(tstate_rd),
    .cwp_o   (cwp_d),
    .pstate_o(pst_d),
    .asi_o   (asi_d),
    .npc_o   (npc_d),
    .nnpc_o  (nnpc_d)
  );

  always_comb begin
    unique case (trs_sel_e'(rd_sel_i))
      SEL_TPC:    rd_data_o = DATA_W'(tpc_rd);
      SEL_TNPC:   rd_data_o = DATA_W'(tnpc_rd);
      SEL_TSTATE: rd_data_o = DATA_W'(tstate_rd);
      default:    rd_data_o = DATA_W'(tt_rd);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_vld_o    <= 1'b0;
      illegal_o    <= 1'b0;
      priv_fault_o <= 1'b0;
      cwp_o        <= '0;
      pstate_o     <= '0;
      asi_o        <= '0;
      npc_o        <= '0;
      nnpc_o       <= '0;
    end else begin
      ret_vld_o    <= ret_ok;
      illegal_o    <= ret_tl_bad | wr_bad;
      priv_fault_o <= ret_priv_bad;
      if (ret_ok) begin
        cwp_o    <= cwp_d;
        pstate_o <= pst_d;
        asi_o    <= asi_d;
        npc_o    <= npc_d;
        nnpc_o   <= nnpc_d;
      end
    end
  end

  assert_one_outcome_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ret_vld_o, illegal_o, priv_fault_o}));

  assert_priv_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && !priv_i && !hpriv_i |=> priv_fault_o && !ret_vld_o && $stable(tl_o));

  assert_tl0_illegal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && (priv_i || hpriv_i) && tl_o == '0 |=> illegal_o && tl_o == '0);

  assert_done_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ok && !ret_fcn_i |=> ret_vld_o && nnpc_o == npc_o + PC_W'(4));

  assert_retry_pc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ok && ret_fcn_i |=> npc_o == $past(tpc_rd));
endmodule

// File: tb/trap_ret_unit_bench.sv
`timescale 1ns/1ps
module trap_ret_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv, hpriv, ret_req, ret_fcn, tl_set, wr_req;
  logic [2:0]  tl_val;
  logic [1:0]  wr_sel, rd_sel;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic [2:0]  tl;
  logic        ret_vld, illegal, pfault;
  logic [4:0]  cwp;
  logic [12:0] pst;
  logic [7:0]  asi;
  logic [63:0] npc, nnpc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_ret_unit u_trap_ret_unit (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .hpriv_i(hpriv),
    .ret_req_i(ret_req), .ret_fcn_i(ret_fcn), .tl_set_i(tl_set), .tl_val_i(tl_val),
    .wr_req_i(wr_req), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .tl_o(tl), .ret_vld_o(ret_vld), .cwp_o(cwp),
    .pstate_o(pst), .asi_o(asi), .npc_o(npc), .nnpc_o(nnpc),
    .illegal_o(illegal), .priv_fault_o(pfault)
  );

  // reference model, index 1..6 = trap level
  int          m_tl = 0;
  logic [63:0] m_ent [1:6][4];
  logic        e_vld, e_ill, e_pf;
  logic [63:0] e_npc, e_nnpc, e_st;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] m_rd(int sel);
    return (m_tl == 0) ? 64'd0 : m_ent[m_tl][sel];
  endfunction

  task automatic cyc(string tag);
    e_vld = 0; e_ill = 0; e_pf = 0;
    if (ret_req) begin
      if (!(priv || hpriv)) e_pf = 1;
      else if (m_tl == 0) e_ill = 1;
      else begin
        e_vld  = 1;
        e_st   = m_ent[m_tl][2];
        e_npc  = ret_fcn ? m_ent[m_tl][0] : m_ent[m_tl][1];
        e_nnpc = ret_fcn ? m_ent[m_tl][1] : m_ent[m_tl][1] + 64'd4;
        m_tl--;
      end
    end else if (tl_set) begin
      m_tl = (tl_val > 3'd6) ? 6 : int'(tl_val);
    end else if (wr_req) begin
      if (m_tl == 0) e_ill = 1;
      else case (wr_sel)
        2'd2:    m_ent[m_tl][2] = {32'd0, wr_data[31:0]};
        2'd3:    m_ent[m_tl][3] = {55'd0, wr_data[8:0]};
        default: m_ent[m_tl][wr_sel] = wr_data;
      endcase
    end
    @(posedge clk);
    #2;
    chk(tag, "tl", 64'(tl), 64'(m_tl));
    chk(tag, "ret_vld", 64'(ret_vld), 64'(e_vld));
    chk(tag, "illegal", 64'(illegal), 64'(e_ill));
    chk(tag, "priv_fault", 64'(pfault), 64'(e_pf));
    chk(tag, "rd_data", rd_data, m_rd(int'(rd_sel)));
    if (e_vld) begin
      chk(tag, "cwp", 64'(cwp), 64'(e_st[4:0]));
      chk(tag, "pstate", 64'(pst), 64'(e_st[20:8]));
      chk(tag, "asi", 64'(asi), 64'(e_st[31:24]));
      chk(tag, "npc", npc, e_npc);
      chk(tag, "nnpc", nnpc, e_nnpc);
    end
    ret_req = 0; tl_set = 0; wr_req = 0;
  endtask

  task automatic set_tl(int v, string tag);
    tl_set = 1; tl_val = 3'(v); cyc(tag);
  endtask

  task automatic wr(int sel, logic [63:0] d, string tag);
    wr_req = 1; wr_sel = 2'(sel); wr_data = d; rd_sel = 2'(sel); cyc(tag);
  endtask

  task automatic ret(bit f, string tag);
    ret_req = 1; ret_fcn = f; cyc(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 1; l <= 6; l++) for (int s = 0; s < 4; s++) m_ent[l][s] = '0;
    priv = 1; hpriv = 0; ret_req = 0; ret_fcn = 0; tl_set = 0; tl_val = 0;
    wr_req = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    #45 rst_n = 1;
    #10;
    // R1 reset state
    chk("R1", "tl", 64'(tl), 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "strobes", 64'({ret_vld, illegal, pfault}), 0);
    @(posedge clk); #2;
    // R2 priv fault at level 0 wins over level check
    priv = 0; hpriv = 0; ret(0, "R2");
    // R3 privileged return at level 0
    priv = 1; ret(1, "R3");
    cyc("R11 strobe clears");
    // R8 write at level 0, then check level 1 untouched
    wr(0, 64'hdead_beef_0000_0001, "R8");
    set_tl(1, "R8");
    for (int s = 0; s < 4; s++) begin rd_sel = 2'(s); cyc("R8 level1 clean"); end
    // R10 saturation
    set_tl(7, "R10");
    set_tl(3, "R10");
    // R9 fill every level
    for (int l = 1; l <= 6; l++) begin
      set_tl(l, "R9");
      wr(0, 64'h1000_0000_0000_0000 + 64'(l) * 64'h40, "R9");
      wr(1, 64'h1000_0000_0000_0004 + 64'(l) * 64'h40, "R9");
      wr(2, {32'hffff_ffff, 8'(l * 17), 3'b0, 13'(l * 321), 3'b0, 5'(l * 5)}, "R9");
      wr(3, 64'h0000_0000_0000_fe00 + 64'(l), "R9");
    end
    for (int s = 0; s < 4; s++) begin rd_sel = 2'(s); cyc("R9 readback"); end
    // R2 at nonzero level: no change
    priv = 0; hpriv = 0; ret(0, "R2");
    // R4 R5 R6 R7 unwind with alternating flavours, hpriv only on some
    rd_sel = 2'd2;
    hpriv = 1; ret(0, "R4/R5/R7 done");
    ret(1, "R4/R6/R7 retry");
    priv = 1; hpriv = 0;
    ret(0, "R5");
    ret(1, "R6");
    // R11 return together with write and tl set: only return acts
    ret_req = 1; ret_fcn = 0; wr_req = 1; wr_sel = 2'd1; wr_data = 64'h5555;
    tl_set = 1; tl_val = 3'd5;
    cyc("R11 priority");
    // R11 tl set beats write
    tl_set = 1; tl_val = 3'd2; wr_req = 1; wr_sel = 2'd0; wr_data = 64'h7777;
    cyc("R11 set over write");
    rd_sel = 2'd0; cyc("R11 write dropped");
    // R5 wrap of next-PC plus 4
    set_tl(1, "R5");
    wr(1, 64'hffff_ffff_ffff_fffe, "R5");
    ret(0, "R5 wrap");
    ret(0, "R3 after unwind");
    ret(1, "R3 retry at zero");
    cyc("R11 idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule